// File: doc/BRIEF.md
# DMA Channel Control and Status Register File

This block is the software-visible register file of a two-channel scatter-gather DMA. One channel moves data out of memory (transmit) and one moves data into memory (receive). Each channel has a window of 48 bytes that holds a control word, a status word, a current-descriptor pointer and a tail-descriptor pointer. The data movers, the completion coalescing counter and the delay timer sit outside the block. They report through single-cycle event inputs and live value inputs, and they are driven by a per-channel interrupt line and a transmit start pulse.

Software sets run, the soft reset and the interrupt enables through the control word. It watches halted, idle and the sticky interrupt flags through the status word, and it clears flags by writing ones to them. Status reads also return the live coalescing count and delay timer value of that channel. A write to the transmit tail pointer starts the transmit descriptor engine. Bus reads answer one cycle after the request.

Top module: `dma_csr_top`

## Requirements
- R1: The channel is bit 0 of (address / 48). Inside a window, offset 0x00 is control, 0x04 status, 0x08 current descriptor and 0x10 tail descriptor. Any other offset, or an address with bits 1:0 not zero, reads as zero, and writes to it change nothing.
- R2: After power-on reset, control reads 0x0001_0002 (threshold field 23:16 = 1, tail mode bit 1 set). Status reads 0x0000_0001 (halted) plus the live fields. irq, tx_start and bus_rvalid are low.
- R3: A control write stores the written word with bit 1 (tail mode) forced to 1.
- R4: A control write is a soft reset when its bit 2 is set, or when control bit 2 is still set from a soft reset in the previous cycle. A soft reset sets control to 0x0001_0006 and status to halted only. Control bit 2 clears by itself on the next clock edge. The other channel is not affected.
- R5: A control write with bit 0 (run) set that is not a soft reset clears status bit 0 (halted) and bit 1 (idle).
- R6: evt_cmpl sets status bit 12 and evt_dly sets status bit 13. evt_idle sets status bit 1. Each bit stays set until it is cleared.
- R7: A status write clears each bit of 14:12 whose written bit is 1. All other written bits are ignored. An event that arrives in the same cycle as the clearing write leaves its flag set.
- R8: irq[c] is high exactly when status[14:12] AND control[14:12] is nonzero for channel c. It follows register state with no extra cycle.
- R9: A status read returns the channel's live coalescing count in bits 23:16 and its delay timer value in bits 31:24, taken in the request cycle.
- R10: A tail write stores the value and clears idle. For channel 0 only, tx_start is high for the one cycle after the write. A receive tail write leaves tx_start low.
- R11: A read request gives bus_rvalid high with bus_rdata in the next cycle. bus_rvalid is low after any cycle with no read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response strobe |
| evt_cmpl | input | 2 | Completion event per channel |
| evt_dly | input | 2 | Delay timeout event per channel |
| evt_idle | input | 2 | Engine reached the tail, per channel |
| coal_cnt_tx | input | 8 | Live coalescing count, transmit |
| coal_cnt_rx | input | 8 | Live coalescing count, receive |
| dly_tmr_tx | input | 8 | Live delay timer, transmit |
| dly_tmr_rx | input | 8 | Live delay timer, receive |
| irq | output | 2 | Masked interrupt per channel |
| tx_start | output | 1 | Start pulse to the transmit engine |

## Verification
The assertions assume that every access lasts one cycle, that each request is separated by its own bus_req cycle, and that event inputs are single-cycle pulses. They also assume the write data bit 2 alone marks a soft reset request. The bench drives every request and event for exactly one clock from the falling edge and deasserts it on the next falling edge. It uses only word-aligned addresses, except for one deliberate misaligned read. It never overlaps a read and a write.

// File: rtl/dma_csr_pkg.sv
// Package: shared constants and the register-select type for the DMA
// channel register file. Assumes 32-bit registers and two channels.
package dma_csr_pkg;
    localparam int DATA_W    = 32;
    localparam int NUM_CH    = 2;
    localparam int WIN_BYTES = 48;
    localparam int LIVE_W    = 8;

    localparam int OFS_CTRL = 'h00;
    localparam int OFS_STAT = 'h04;
    localparam int OFS_CUR  = 'h08;
    localparam int OFS_TAIL = 'h10;

    localparam int BIT_RUN   = 0;
    localparam int BIT_TAILM = 1;
    localparam int BIT_SRST  = 2;
    localparam int BIT_HALT  = 0;
    localparam int BIT_IDLE  = 1;
    localparam int IRQ_LO    = 12;
    localparam int IRQ_W     = 3;
    localparam int THR_LO    = 16;
    localparam int CNT_LO    = 16;
    localparam int TMR_LO    = 24;

    localparam logic [DATA_W-1:0] CTRL_INIT =
        (DATA_W'(1) << THR_LO) | (DATA_W'(1) << BIT_TAILM);
    localparam logic [DATA_W-1:0] CTRL_SRST =
        CTRL_INIT | (DATA_W'(1) << BIT_SRST);

    typedef enum logic [2:0] {
        SEL_CTRL,
        SEL_STAT,
        SEL_CUR,
        SEL_TAIL,
        SEL_NONE
    } reg_sel_t;
endpackage

// File: rtl/dma_csr_decode.sv
// Address decoder: maps a byte address to a channel index and a register
// select. Assumes word accesses; a misaligned address selects nothing.
module dma_csr_decode
    import dma_csr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              chan,
    output reg_sel_t          sel
);
    localparam logic [ADDR_W-1:0] WIN = ADDR_W'(WIN_BYTES);

    logic [ADDR_W-1:0] ofs;

    // Offset inside the window and the channel parity of the window index
    always_comb begin
        ofs  = addr % WIN;
        chan = 1'((addr / WIN) & ADDR_W'(1));
    end

    // Register select from the in-window offset
    always_comb begin
        if (ofs[1:0] != 2'b00) begin
            sel = SEL_NONE;
        end else if (ofs == ADDR_W'(OFS_CTRL)) begin
            sel = SEL_CTRL;
        end else if (ofs == ADDR_W'(OFS_STAT)) begin
            sel = SEL_STAT;
        end else if (ofs == ADDR_W'(OFS_CUR)) begin
            sel = SEL_CUR;
        end else if (ofs == ADDR_W'(OFS_TAIL)) begin
            sel = SEL_TAIL;
        end else begin
            sel = SEL_NONE;
        end
    end
endmodule

// File: rtl/dma_csr_chan.sv
// One channel's registers: control, status flags, descriptor pointers,
// masked interrupt and optional start pulse. Assumes wr_en is a single
// cycle strobe already qualified by the channel decode.
module dma_csr_chan
    import dma_csr_pkg::*;
#(
    parameter bit HAS_START = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_t          sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              cmpl_evt,
    input  logic              dly_evt,
    input  logic              idle_evt,
    input  logic [LIVE_W-1:0] live_cnt,
    input  logic [LIVE_W-1:0] live_tmr,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] stat_view,
    output logic [DATA_W-1:0] cur_q,
    output logic [DATA_W-1:0] tail_q,
    output logic              irq,
    output logic              start_pulse
);
    logic              wr_ctrl, wr_stat, wr_cur, wr_tail;
    logic [DATA_W-1:0] ctrl_eff;
    logic              soft_rst, run_go;
    logic              halted_q, idle_q;
    logic [IRQ_W-1:0]  flags_q, clr_mask, set_mask;

    // Per-register write strobes and the effective control word
    always_comb begin
        wr_ctrl  = wr_en && (sel == SEL_CTRL);
        wr_stat  = wr_en && (sel == SEL_STAT);
        wr_cur   = wr_en && (sel == SEL_CUR);
        wr_tail  = wr_en && (sel == SEL_TAIL);
        ctrl_eff = wdata | (DATA_W'(1) << BIT_TAILM)
                 | (ctrl_q & (DATA_W'(1) << BIT_SRST));
        soft_rst = wr_ctrl && ctrl_eff[BIT_SRST];
        run_go   = wr_ctrl && ctrl_eff[BIT_RUN] && !soft_rst;
        clr_mask = wr_stat ? wdata[IRQ_LO +: IRQ_W] : '0;
        set_mask = {1'b0, dly_evt, cmpl_evt};
    end

    // Control word with the self-clearing soft reset flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_INIT;
        end else if (soft_rst) begin
            ctrl_q <= CTRL_SRST;
        end else if (wr_ctrl) begin
            ctrl_q <= ctrl_eff;
        end else if (ctrl_q[BIT_SRST]) begin
            ctrl_q[BIT_SRST] <= 1'b0;
        end
    end

    // Halted flag: set by any reset, cleared by a run request
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            halted_q <= 1'b1;
        end else if (run_go) begin
            halted_q <= 1'b0;
        end
    end

    // Idle flag: cleared by run or new tail, set by the engine
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            idle_q <= 1'b0;
        end else if (run_go || wr_tail) begin
            idle_q <= 1'b0;
        end else if (idle_evt) begin
            idle_q <= 1'b1;
        end
    end

    // Sticky interrupt flags: write-one-to-clear, events win
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            flags_q <= '0;
        end else begin
            flags_q <= (flags_q & ~clr_mask) | set_mask;
        end
    end

    // Descriptor pointer storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= '0;
            tail_q <= '0;
        end else begin
            if (wr_cur)  cur_q  <= wdata;
            if (wr_tail) tail_q <= wdata;
        end
    end

    // Start pulse only on channels that own a descriptor engine kick
    generate
        if (HAS_START) begin : g_start
            logic start_q;
            // One-cycle start after a tail write
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    start_q <= 1'b0;
                end else begin
                    start_q <= wr_tail;
                end
            end
            assign start_pulse = start_q;
        end else begin : g_nostart
            assign start_pulse = 1'b0;
        end
    endgenerate

    // Masked interrupt and the merged status view
    always_comb begin
        irq       = |(flags_q & ctrl_q[IRQ_LO +: IRQ_W]);
        stat_view = '0;
        stat_view[BIT_HALT]             = halted_q;
        stat_view[BIT_IDLE]             = idle_q;
        stat_view[IRQ_LO +: IRQ_W]      = flags_q;
        stat_view[CNT_LO +: LIVE_W]     = live_cnt;
        stat_view[TMR_LO +: LIVE_W]     = live_tmr;
    end
endmodule

// File: rtl/dma_csr_rdmux.sv
// Read path: selects the addressed register and registers the response.
// Assumes a read request lasts one cycle; unknown selects return zero.
module dma_csr_rdmux
    import dma_csr_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           rd_en,
    input  logic                           chan,
    input  reg_sel_t                       sel,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  ctrl_all,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  stat_all,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  cur_all,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  tail_all,
    output logic [DATA_W-1:0]              rdata_q,
    output logic                           rvalid_q
);
    logic [DATA_W-1:0] rd_word;

    // Register select for the addressed channel
    always_comb begin
        unique case (sel)
            SEL_CTRL: rd_word = ctrl_all[chan];
            SEL_STAT: rd_word = stat_all[chan];
            SEL_CUR:  rd_word = cur_all[chan];
            SEL_TAIL: rd_word = tail_all[chan];
            default:  rd_word = '0;
        endcase
    end

    // Registered response, one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= rd_en;
            if (rd_en) rdata_q <= rd_word;
        end
    end
endmodule

// File: rtl/dma_csr_top.sv
// Top of the two-channel DMA register file: decode, per-channel registers
// and read response. Channel 0 transmits and owns the start pulse.
module dma_csr_top
    import dma_csr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    input  logic [1:0]        evt_cmpl,
    input  logic [1:0]        evt_dly,
    input  logic [1:0]        evt_idle,
    input  logic [7:0]        coal_cnt_tx,
    input  logic [7:0]        coal_cnt_rx,
    input  logic [7:0]        dly_tmr_tx,
    input  logic [7:0]        dly_tmr_rx,
    output logic [1:0]        irq,
    output logic              tx_start
);
    logic                          dec_chan;
    reg_sel_t                      dec_sel;
    logic [NUM_CH-1:0][DATA_W-1:0] ctrl_all, stat_all, cur_all, tail_all;
    logic [NUM_CH-1:0][LIVE_W-1:0] cnt_all, tmr_all;
    logic [NUM_CH-1:0]             start_all;

    // Gather the live counter inputs by channel
    always_comb begin
        cnt_all = {coal_cnt_rx, coal_cnt_tx};
        tmr_all = {dly_tmr_rx, dly_tmr_tx};
    end

    dma_csr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .chan (dec_chan),
        .sel  (dec_sel)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            dma_csr_chan #(.HAS_START(c == 0)) u_chan (
                .clk         (clk),
                .rst_n       (rst_n),
                .wr_en       (bus_req && bus_we && (dec_chan == 1'(c))),
                .sel         (dec_sel),
                .wdata       (bus_wdata),
                .cmpl_evt    (evt_cmpl[c]),
                .dly_evt     (evt_dly[c]),
                .idle_evt    (evt_idle[c]),
                .live_cnt    (cnt_all[c]),
                .live_tmr    (tmr_all[c]),
                .ctrl_q      (ctrl_all[c]),
                .stat_view   (stat_all[c]),
                .cur_q       (cur_all[c]),
                .tail_q      (tail_all[c]),
                .irq         (irq[c]),
                .start_pulse (start_all[c])
            );
        end
    endgenerate

    dma_csr_rdmux u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (bus_req && !bus_we),
        .chan     (dec_chan),
        .sel      (dec_sel),
        .ctrl_all (ctrl_all),
        .stat_all (stat_all),
        .cur_all  (cur_all),
        .tail_all (tail_all),
        .rdata_q  (bus_rdata),
        .rvalid_q (bus_rvalid)
    );

    // Only the transmit channel drives a start; the rest are tied low
    assign tx_start = |start_all;
endmodule

// File: rtl/dma_csr_checker.sv
// Checker bound to dma_csr_top: response timing, start source, soft reset
// self-clear, sticky completion flag and interrupt causes.
module dma_csr_checker #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              wr_srst_bit,
    input logic              bus_rvalid,
    input logic [1:0]        evt_cmpl,
    input logic [1:0]        evt_dly,
    input logic [1:0]        irq,
    input logic              tx_start,
    input logic [1:0][31:0]  ctrl_all,
    input logic [1:0][31:0]  stat_all
);
    localparam logic [ADDR_W-1:0] WIN = ADDR_W'(48);

    logic [ADDR_W-1:0] a_ofs;
    logic              a_ch;
    logic              rd_req, wr_req;

    always_comb begin
        a_ofs  = bus_addr % WIN;
        a_ch   = 1'((bus_addr / WIN) & ADDR_W'(1));
        rd_req = bus_req && !bus_we;
        wr_req = bus_req && bus_we;
    end

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> bus_rvalid);                                   // R11
    AST_NO_SPURIOUS_RV: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !bus_rvalid);                                 // R11
    AST_START_FROM_TX_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> $past(wr_req && !a_ch && a_ofs == ADDR_W'('h10))); // R10

    generate
        for (genvar c = 0; c < 2; c++) begin : g_chk
            logic ctrl_hit;
            assign ctrl_hit = wr_req && (a_ch == 1'(c)) && (a_ofs == '0);

            AST_SRST_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
                (ctrl_all[c][2] && !ctrl_hit) |=> !ctrl_all[c][2]);    // R4
            AST_CMPL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                (evt_cmpl[c] && !(ctrl_hit && (wr_srst_bit || ctrl_all[c][2])))
                |=> stat_all[c][12]);                                 // R6
            AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(irq[c]) |-> $past(evt_cmpl[c] || evt_dly[c] || wr_req)); // R8
        end
    endgenerate
endmodule

bind dma_csr_top dma_csr_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_req     (bus_req),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .wr_srst_bit (bus_wdata[2]),
    .bus_rvalid  (bus_rvalid),
    .evt_cmpl    (evt_cmpl),
    .evt_dly     (evt_dly),
    .irq         (irq),
    .tx_start    (tx_start),
    .ctrl_all    (ctrl_all),
    .stat_all    (stat_all)
);

// File: tb/dma_csr_top_test.sv
// Bench for dma_csr_top: a vector table of register accesses, then
// directed tests for events, clearing, resets and start pulses.
module dma_csr_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [1:0]  evt_cmpl = '0, evt_dly = '0, evt_idle = '0;
    logic [7:0]  coal_cnt_tx = '0, coal_cnt_rx = '0, dly_tmr_tx = '0, dly_tmr_rx = '0;
    logic [1:0]  irq;
    logic        tx_start;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    dma_csr_top #(.ADDR_W(8)) uut (.*);

    // {req id[3:0], write, addr[7:0], wdata[31:0], expected[31:0]}
    localparam int NV = 16;
    localparam logic [76:0] VEC [NV] = '{
        {4'd2, 1'b0, 8'h00, 32'h0,         32'h0001_0002},
        {4'd2, 1'b0, 8'h04, 32'h0,         32'h0000_0001},
        {4'd2, 1'b0, 8'h30, 32'h0,         32'h0001_0002},
        {4'd2, 1'b0, 8'h34, 32'h0,         32'h0000_0001},
        {4'd1, 1'b1, 8'h08, 32'hDEAD_BEE0, 32'h0},
        {4'd1, 1'b0, 8'h08, 32'h0,         32'hDEAD_BEE0},
        {4'd1, 1'b1, 8'h38, 32'h1234_5670, 32'h0},
        {4'd1, 1'b0, 8'h38, 32'h0,         32'h1234_5670},
        {4'd1, 1'b0, 8'h08, 32'h0,         32'hDEAD_BEE0},
        {4'd1, 1'b1, 8'h0C, 32'hFFFF_FFFF, 32'h0},
        {4'd1, 1'b0, 8'h0C, 32'h0,         32'h0000_0000},
        {4'd3, 1'b1, 8'h00, 32'h0000_7000, 32'h0},
        {4'd3, 1'b0, 8'h00, 32'h0,         32'h0000_7002},
        {4'd3, 1'b0, 8'h04, 32'h0,         32'h0000_0001},
        {4'd1, 1'b0, 8'h60, 32'h0,         32'h0000_7002},
        {4'd1, 1'b0, 8'h02, 32'h0,         32'h0000_0000}
    };

    function automatic string rtag(input int id);
        case (id)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            default: return "R?";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
        chk("R11 rvalid", {31'b0, bus_rvalid}, 32'h1);
        d = bus_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    // kind 0 = completion, 1 = delay, 2 = idle
    task automatic ev(input int kind, input int ch);
        case (kind)
            0: evt_cmpl[ch] = 1'b1;
            1: evt_dly[ch]  = 1'b1;
            default: evt_idle[ch] = 1'b1;
        endcase
        @(negedge clk);
        evt_cmpl = '0; evt_dly = '0; evt_idle = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: outputs quiet after reset
        chk("R2 irq", {30'b0, irq}, 32'h0);
        chk("R2 tx_start", {31'b0, tx_start}, 32'h0);
        chk("R2 rvalid", {31'b0, bus_rvalid}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][72]) begin
                wr(VEC[i][71:64], VEC[i][63:32]);
            end else begin
                rd_chk(rtag(int'(VEC[i][76:73])), VEC[i][71:64], VEC[i][31:0]);
            end
        end

        // R5: run clears halted and idle
        wr(8'h00, 32'h0000_0001);
        chk("R11 no rvalid after write", {31'b0, bus_rvalid}, 32'h0);
        rd_chk("R5", 8'h04, 32'h0000_0000);

        // R6/R8: completion flag raises irq when enabled
        wr(8'h00, 32'h0000_1001);
        ev(0, 0);
        chk("R8 irq on cmpl", {30'b0, irq}, 32'h1);
        rd_chk("R6 cmpl flag", 8'h04, 32'h0000_1000);
        ev(1, 0);
        rd_chk("R6 dly flag", 8'h04, 32'h0000_3000);
        chk("R8 irq held", {30'b0, irq}, 32'h1);

        // R7: write-one-to-clear, other bits ignored
        wr(8'h04, 32'h0000_1000);
        chk("R8 irq after clear", {30'b0, irq}, 32'h0);
        wr(8'h04, 32'h0000_0003);
        rd_chk("R7 other bits ignored", 8'h04, 32'h0000_2000);

        // R7: event in the clearing cycle wins
        evt_cmpl[0] = 1'b1;
        wr(8'h04, 32'h0000_1000);
        evt_cmpl = '0;
        rd_chk("R7 event wins", 8'h04, 32'h0000_3000);
        wr(8'h04, 32'h0000_7000);
        rd_chk("R7 all cleared", 8'h04, 32'h0000_0000);

        // R9: live counter and timer merge
        coal_cnt_tx = 8'h5A; dly_tmr_tx = 8'hC3;
        coal_cnt_rx = 8'h11; dly_tmr_rx = 8'h22;
        rd_chk("R9 tx live", 8'h04, 32'hC35A_0000);
        rd_chk("R9 rx live", 8'h34, 32'h2211_0001);
        coal_cnt_tx = '0; dly_tmr_tx = '0; coal_cnt_rx = '0; dly_tmr_rx = '0;

        // R6: idle event
        ev(2, 0);
        rd_chk("R6 idle", 8'h04, 32'h0000_0002);

        // R10: transmit tail write pulses start and clears idle
        wr(8'h10, 32'h0000_0200);
        chk("R10 tx_start high", {31'b0, tx_start}, 32'h1);
        @(negedge clk);
        chk("R10 tx_start one cycle", {31'b0, tx_start}, 32'h0);
        rd_chk("R10 idle cleared", 8'h04, 32'h0000_0000);
        rd_chk("R10 tail stored", 8'h10, 32'h0000_0200);

        // R10: receive tail write gives no start
        wr(8'h30, 32'h0000_2001);
        ev(2, 1);
        wr(8'h40, 32'h0000_0080);
        chk("R10 rx no start", {31'b0, tx_start}, 32'h0);
        rd_chk("R10 rx idle cleared", 8'h34, 32'h0000_0000);

        // R8: receive irq independent of transmit
        ev(1, 1);
        chk("R8 rx irq", {30'b0, irq}, 32'h2);

        // R4: soft reset and self clear
        wr(8'h00, 32'h0000_0004);
        rd_chk("R4 reset bit seen", 8'h00, 32'h0001_0006);
        rd_chk("R4 reset bit cleared", 8'h00, 32'h0001_0002);
        rd_chk("R4 status halted", 8'h04, 32'h0000_0001);
        rd_chk("R4 other channel kept", 8'h34, 32'h0000_2000);

        // R4: run right after reset is still a reset
        wr(8'h00, 32'h0000_0004);
        wr(8'h00, 32'h0000_0001);
        rd_chk("R4 back-to-back stays halted", 8'h04, 32'h0000_0001);

        // R5: run after the flag cleared starts the channel
        @(negedge clk);
        wr(8'h00, 32'h0000_0001);
        rd_chk("R5 run after reset", 8'h04, 32'h0000_0000);

        finish_run();
    end
endmodule